// File: doc/BRIEF.md
# Timestamp register bank

This block is the 32-bit Wishbone (pipelined) slave that sits between a host bus and a time-tagging unit. It presents six timestamps to software, each a 40-bit seconds value and a 28-bit count of 125 MHz system clock ticks. The six are the running time, a programmable trigger time and four captured event stamps: trigger, acquisition start, acquisition stop and acquisition end.

The running-time words keep no copy in this block. A bus write sends a single-cycle load pulse and the written value to the counter logic. A read returns whatever the counter logic supplies at that moment. The trigger-time words are plain storage, and together they drive the trigger-time outputs. The event words are read-only views of the device inputs. The counters and the capture logic live outside the block.

Top module: `tstamp_reg_bank`

## Requirements
- R1: Each cycle with both cyc and stb high is acknowledged in the very next cycle, and only then. Stall, err and rty stay low at all times.
- R2: The bus is byte addressed. Address bits 6..2 select a 32-bit word, and bits 1..0 are ignored. Each timestamp uses three consecutive words: first seconds bits 39..32 in data bits 7..0, then seconds bits 31..0, then the tick count in bits 27..0. The unused upper bits read as zero. The stamps start at byte offsets 0x00 (running time), 0x0C (trigger time), 0x18 (trigger event), 0x24 (acquisition start), 0x30 (acquisition stop) and 0x3C (acquisition end). A read of a running-time word returns the live counter input as sampled in the request cycle, with the data valid alongside the acknowledge.
- R3: A write to running-time word 0, 1 or 2 raises only that word's load pulse for exactly the acknowledge cycle. The pulse carries the written data cut to the field width (8, 32 or 28 bits). No other access raises a load pulse.
- R4: The three trigger-time words are stored locally, with bits beyond the field width dropped. They read back as stored and drive the trigger-time outputs from the acknowledge cycle onward. They change only on a write to them.
- R5: The twelve event words read the device event inputs directly. Writes to them are acknowledged and change nothing.
- R6: Word indices 18 to 31 read as zero. Writes to them are acknowledged and change nothing.
- R7: An active-low asynchronous reset clears the trigger-time storage, the acknowledge and all load pulses.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 7 | Byte address |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Acknowledge |
| wb_stall_o | output | 1 | Stall, always low |
| wb_err_o | output | 1 | Error, always low |
| wb_rty_o | output | 1 | Retry, always low |
| now_sec_i | input | 40 | Live seconds from the counter logic |
| now_tick_i | input | 28 | Live tick count from the counter logic |
| ld_sec_hi_o | output | 1 | Load pulse, seconds bits 39..32 |
| ld_sec_lo_o | output | 1 | Load pulse, seconds bits 31..0 |
| ld_tick_o | output | 1 | Load pulse, tick count |
| ld_sec_hi_val_o | output | 8 | Value for the upper seconds load |
| ld_sec_lo_val_o | output | 32 | Value for the lower seconds load |
| ld_tick_val_o | output | 28 | Value for the tick load |
| trg_sec_o | output | 40 | Trigger time, seconds |
| trg_tick_o | output | 28 | Trigger time, ticks |
| evt_sec_i | input | 4x40 | Event seconds (0 trigger, 1 acq start, 2 acq stop, 3 acq end) |
| evt_tick_i | input | 4x28 | Event ticks, same order |

## Verification
The assertions assume that the bus inputs are settled at every rising edge and that a master issues at most one request per cycle. They do not assume that a request is separated from the next by idle cycles, so stalls and back-to-back traffic are both legal.

The stimulus changes bus inputs and device values only on the falling edge. It mixes isolated accesses with pipelined bursts that hold cyc and stb across many cycles. It lets the modelled counter roll its tick count over while reads are in flight. Reset is raised once during operation.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
  localparam int DW              = 32;
  localparam int SEC_W           = 40;
  localparam int TICK_W          = 28;
  localparam int SEC_HI_W        = SEC_W - DW;
  localparam int WORDS_PER_STAMP = 3;
  localparam int N_EVT           = 4;
  localparam int STAMP_NOW       = 0;
  localparam int STAMP_TRG       = 1;
  localparam int STAMP_EVT0      = 2;
  localparam int N_STAMP         = STAMP_EVT0 + N_EVT;
  localparam int N_WORDS         = N_STAMP * WORDS_PER_STAMP;

  typedef struct packed {
    logic [SEC_W-1:0]  sec;
    logic [TICK_W-1:0] tick;
  } stamp_t;

  typedef enum logic [1:0] {
    F_SEC_HI = 2'd0,
    F_SEC_LO = 2'd1,
    F_TICK   = 2'd2
  } field_e;

  function automatic logic [DW-1:0] stamp_word(stamp_t s, field_e f);
    logic [DW-1:0] w;
    w = '0;
    case (f)
      F_SEC_HI: w[SEC_HI_W-1:0] = s.sec[SEC_W-1:DW];
      F_SEC_LO: w               = s.sec[DW-1:0];
      F_TICK:   w[TICK_W-1:0]   = s.tick;
      default:  w               = '0;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/tsb_bus_port.sv
module tsb_bus_port
  import tsb_pkg::*;
#(
  parameter int ADR_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cyc_i,
  input  logic             stb_i,
  input  logic             we_i,
  input  logic [ADR_W-1:0] adr_i,
  output logic             wr_o,
  output logic             rd_o,
  output logic [ADR_W-3:0] grp_o,
  output field_e           fld_o,
  output logic             ack_o
);
  localparam int WIDX_W = ADR_W - 2;

  logic              req;
  logic [WIDX_W-1:0] widx;
  logic [WIDX_W-1:0] sub_full;
  logic              unused_bits;

  assign req         = cyc_i & stb_i;
  assign wr_o        = req & we_i;
  assign rd_o        = req & ~we_i;
  assign widx        = adr_i[ADR_W-1:2];
  assign grp_o       = widx / WIDX_W'(WORDS_PER_STAMP);
  assign sub_full    = widx % WIDX_W'(WORDS_PER_STAMP);
  assign fld_o       = field_e'(sub_full[1:0]);
  assign unused_bits = ^{adr_i[1:0], sub_full[WIDX_W-1:2]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_o <= 1'b0;
    else         ack_o <= req;
  end
endmodule

// File: rtl/tsb_write_path.sv
module tsb_write_path
  import tsb_pkg::*;
#(
  parameter int GRP_W = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [GRP_W-1:0]    grp_i,
  input  field_e              fld_i,
  input  logic [DW-1:0]       dat_i,
  output logic                ld_hi_o,
  output logic                ld_lo_o,
  output logic                ld_tick_o,
  output logic [SEC_HI_W-1:0] ld_hi_val_o,
  output logic [DW-1:0]       ld_lo_val_o,
  output logic [TICK_W-1:0]   ld_tick_val_o,
  output stamp_t              trg_o
);
  logic wr_now, wr_trg;

  assign wr_now = wr_i && (grp_i == GRP_W'(STAMP_NOW));
  assign wr_trg = wr_i && (grp_i == GRP_W'(STAMP_TRG));

  // load pulses toward the counter logic; no local copy of running time
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_hi_o       <= 1'b0;
      ld_lo_o       <= 1'b0;
      ld_tick_o     <= 1'b0;
      ld_hi_val_o   <= '0;
      ld_lo_val_o   <= '0;
      ld_tick_val_o <= '0;
    end else begin
      ld_hi_o   <= wr_now && (fld_i == F_SEC_HI);
      ld_lo_o   <= wr_now && (fld_i == F_SEC_LO);
      ld_tick_o <= wr_now && (fld_i == F_TICK);
      if (wr_now) begin
        ld_hi_val_o   <= dat_i[SEC_HI_W-1:0];
        ld_lo_val_o   <= dat_i;
        ld_tick_val_o <= dat_i[TICK_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trg_o <= '0;
    end else if (wr_trg) begin
      case (fld_i)
        F_SEC_HI: trg_o.sec[SEC_W-1:DW] <= dat_i[SEC_HI_W-1:0];
        F_SEC_LO: trg_o.sec[DW-1:0]     <= dat_i;
        F_TICK:   trg_o.tick            <= dat_i[TICK_W-1:0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/tsb_read_mux.sv
module tsb_read_mux
  import tsb_pkg::*;
#(
  parameter int GRP_W = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   rd_i,
  input  logic [GRP_W-1:0]       grp_i,
  input  field_e                 fld_i,
  input  stamp_t                 now_i,
  input  stamp_t                 trg_i,
  input  stamp_t [N_EVT-1:0]     evt_i,
  output logic [DW-1:0]          dat_o
);
  stamp_t        tbl [N_STAMP];
  logic [DW-1:0] rd_word;

  assign tbl[STAMP_NOW] = now_i;
  assign tbl[STAMP_TRG] = trg_i;
  for (genvar k = 0; k < N_EVT; k++) begin : g_evt
    assign tbl[STAMP_EVT0+k] = evt_i[k];
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < N_STAMP; i++)
      if (grp_i == GRP_W'(i)) rd_word = stamp_word(tbl[i], fld_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dat_o <= '0;
    else         dat_o <= rd_i ? rd_word : '0;
  end
endmodule

// File: rtl/tstamp_reg_bank.sv
module tstamp_reg_bank
  import tsb_pkg::*;
#(
  parameter int ADR_W = 7
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wb_cyc_i,
  input  logic                             wb_stb_i,
  input  logic                             wb_we_i,
  input  logic [ADR_W-1:0]                 wb_adr_i,
  input  logic [DW-1:0]                    wb_dat_i,
  output logic [DW-1:0]                    wb_dat_o,
  output logic                             wb_ack_o,
  output logic                             wb_stall_o,
  output logic                             wb_err_o,
  output logic                             wb_rty_o,
  input  logic [SEC_W-1:0]                 now_sec_i,
  input  logic [TICK_W-1:0]                now_tick_i,
  output logic                             ld_sec_hi_o,
  output logic                             ld_sec_lo_o,
  output logic                             ld_tick_o,
  output logic [SEC_HI_W-1:0]              ld_sec_hi_val_o,
  output logic [DW-1:0]                    ld_sec_lo_val_o,
  output logic [TICK_W-1:0]                ld_tick_val_o,
  output logic [SEC_W-1:0]                 trg_sec_o,
  output logic [TICK_W-1:0]                trg_tick_o,
  input  logic [N_EVT-1:0][SEC_W-1:0]      evt_sec_i,
  input  logic [N_EVT-1:0][TICK_W-1:0]     evt_tick_i
);
  localparam int GRP_W = ADR_W - 2;

  logic               wr, rd;
  logic [GRP_W-1:0]   grp;
  field_e             fld;
  stamp_t             trg;
  stamp_t             now;
  stamp_t [N_EVT-1:0] evt;

  assign wb_stall_o = 1'b0;
  assign wb_err_o   = 1'b0;
  assign wb_rty_o   = 1'b0;
  assign now        = {now_sec_i, now_tick_i};
  assign trg_sec_o  = trg.sec;
  assign trg_tick_o = trg.tick;

  for (genvar k = 0; k < N_EVT; k++) begin : g_evt
    assign evt[k] = {evt_sec_i[k], evt_tick_i[k]};
  end

  tsb_bus_port #(.ADR_W(ADR_W)) u_bus (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cyc_i  (wb_cyc_i),
    .stb_i  (wb_stb_i),
    .we_i   (wb_we_i),
    .adr_i  (wb_adr_i),
    .wr_o   (wr),
    .rd_o   (rd),
    .grp_o  (grp),
    .fld_o  (fld),
    .ack_o  (wb_ack_o)
  );

  tsb_write_path #(.GRP_W(GRP_W)) u_wr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_i          (wr),
    .grp_i         (grp),
    .fld_i         (fld),
    .dat_i         (wb_dat_i),
    .ld_hi_o       (ld_sec_hi_o),
    .ld_lo_o       (ld_sec_lo_o),
    .ld_tick_o     (ld_tick_o),
    .ld_hi_val_o   (ld_sec_hi_val_o),
    .ld_lo_val_o   (ld_sec_lo_val_o),
    .ld_tick_val_o (ld_tick_val_o),
    .trg_o         (trg)
  );

  tsb_read_mux #(.GRP_W(GRP_W)) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (rd),
    .grp_i  (grp),
    .fld_i  (fld),
    .now_i  (now),
    .trg_i  (trg),
    .evt_i  (evt),
    .dat_o  (wb_dat_o)
  );
endmodule

// File: rtl/tsb_checker.sv
module tsb_checker
  import tsb_pkg::*;
#(
  parameter int ADR_W = 7
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wb_cyc_i,
  input logic               wb_stb_i,
  input logic               wb_we_i,
  input logic [ADR_W-1:0]   wb_adr_i,
  input logic [DW-1:0]      wb_dat_o,
  input logic               wb_ack_o,
  input logic               wb_stall_o,
  input logic               wb_err_o,
  input logic               wb_rty_o,
  input logic               ld_sec_hi_o,
  input logic               ld_sec_lo_o,
  input logic               ld_tick_o,
  input logic [SEC_W-1:0]   trg_sec_o,
  input logic [TICK_W-1:0]  trg_tick_o
);
  localparam int WIDX_W = ADR_W - 2;

  logic              req, wreq, rreq, mapped, hi_word, tick_word, unused_lsb;
  logic [WIDX_W-1:0] widx;

  assign req        = wb_cyc_i && wb_stb_i;
  assign wreq       = req && wb_we_i;
  assign rreq       = req && !wb_we_i;
  assign widx       = wb_adr_i[ADR_W-1:2];
  assign mapped     = widx < WIDX_W'(N_WORDS);
  assign hi_word    = mapped && (widx % WIDX_W'(WORDS_PER_STAMP) == WIDX_W'(0));
  assign tick_word  = mapped && (widx % WIDX_W'(WORDS_PER_STAMP) == WIDX_W'(2));
  assign unused_lsb = ^wb_adr_i[1:0];

  p_ack_next_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req |=> wb_ack_o);
  p_ack_only_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req |=> !wb_ack_o);
  p_flow_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wb_stall_o && !wb_err_o && !wb_rty_o);
  p_hi_pad_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rreq && hi_word) |=> (wb_dat_o[DW-1:SEC_HI_W] == '0));
  p_tick_pad_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rreq && tick_word) |=> (wb_dat_o[DW-1:TICK_W] == '0));
  p_ld_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ld_sec_hi_o, ld_sec_lo_o, ld_tick_o}));
  p_ld_hi_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_sec_hi_o |-> $past(wreq && widx == WIDX_W'(0)));
  p_ld_lo_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_sec_lo_o |-> $past(wreq && widx == WIDX_W'(1)));
  p_ld_tick_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_tick_o |-> $past(wreq && widx == WIDX_W'(2)));
  p_trg_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wreq |=> $stable({trg_sec_o, trg_tick_o}));
  p_unmapped_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rreq && !mapped) |=> (wb_dat_o == '0));
endmodule

bind tstamp_reg_bank tsb_checker #(.ADR_W(ADR_W)) u_tsb_chk (.*);

// File: tb/tstamp_reg_bank_test.sv
`timescale 1ns/1ps
module tstamp_reg_bank_test;
  import tsb_pkg::*;

  localparam int TICK_MAX = 125000000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [6:0]  adr = '0;
  logic [31:0] dat_w = '0;
  logic [31:0] dat_r;
  logic ack, stall, err, rty;
  logic [SEC_W-1:0]  now_sec  = '0;
  logic [TICK_W-1:0] now_tick = '0;
  logic ld_hi, ld_lo, ld_tk;
  logic [7:0]  ld_hi_v;
  logic [31:0] ld_lo_v;
  logic [27:0] ld_tk_v;
  logic [SEC_W-1:0]  trg_sec;
  logic [TICK_W-1:0] trg_tick;
  logic [N_EVT-1:0][SEC_W-1:0]  evt_sec  = '0;
  logic [N_EVT-1:0][TICK_W-1:0] evt_tick = '0;

  logic [SEC_W-1:0]  m_trg_sec  = '0;
  logic [TICK_W-1:0] m_trg_tick = '0;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tstamp_reg_bank uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we), .wb_adr_i(adr), .wb_dat_i(dat_w),
    .wb_dat_o(dat_r), .wb_ack_o(ack), .wb_stall_o(stall), .wb_err_o(err), .wb_rty_o(rty),
    .now_sec_i(now_sec), .now_tick_i(now_tick),
    .ld_sec_hi_o(ld_hi), .ld_sec_lo_o(ld_lo), .ld_tick_o(ld_tk),
    .ld_sec_hi_val_o(ld_hi_v), .ld_sec_lo_val_o(ld_lo_v), .ld_tick_val_o(ld_tk_v),
    .trg_sec_o(trg_sec), .trg_tick_o(trg_tick),
    .evt_sec_i(evt_sec), .evt_tick_i(evt_tick)
  );

  task automatic chk(bit ok, string tag, logic [71:0] act, logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // counter logic stand-in
  always @(negedge clk) begin
    if (!rst_ni) begin
      now_sec  <= '0;
      now_tick <= '0;
    end else begin
      if (ld_hi)      now_sec[39:32] <= ld_hi_v;
      else if (ld_lo) now_sec[31:0]  <= ld_lo_v;
      if (ld_tk) now_tick <= ld_tk_v;
      else if (now_tick == 28'(TICK_MAX - 1)) begin
        now_tick <= '0;
        if (!ld_hi && !ld_lo) now_sec <= now_sec + 1;
      end else now_tick <= now_tick + 1;
    end
  end

  function automatic logic [31:0] ref_read(int w);
    logic [39:0] s;
    logic [27:0] t;
    if (w >= 18) return 32'h0;
    if (w < 3)      begin s = now_sec;   t = now_tick;   end
    else if (w < 6) begin s = m_trg_sec; t = m_trg_tick; end
    else            begin s = evt_sec[(w-6)/3]; t = evt_tick[(w-6)/3]; end
    case (w % 3)
      0:       return {24'h0, s[39:32]};
      1:       return s[31:0];
      default: return {4'h0, t};
    endcase
  endfunction

  // reference comparison on every clock
  always @(posedge clk) begin
    #2;
    if (!rst_ni) begin
      m_trg_sec  = '0;
      m_trg_tick = '0;
      chk(ack == 1'b0, "R7 ack in reset", 72'(ack), 72'(0));
      chk({ld_hi, ld_lo, ld_tk} == 3'b0, "R7 load pulses in reset", 72'({ld_hi, ld_lo, ld_tk}), 72'(0));
      chk({trg_sec, trg_tick} == '0, "R7 trigger time in reset", 72'({trg_sec, trg_tick}), 72'(0));
    end else begin
      automatic bit req = cyc && stb;
      automatic int w = int'(adr[6:2]);
      automatic logic [2:0] exp_ld = '0;
      chk(ack == req, "R1 ack", 72'(ack), 72'(req));
      chk({stall, err, rty} == 3'b0, "R1 stall/err/rty", 72'({stall, err, rty}), 72'(0));
      if (req && we && w < 3) exp_ld[2 - w] = 1'b1;
      chk({ld_hi, ld_lo, ld_tk} == exp_ld, "R3 load pulses", 72'({ld_hi, ld_lo, ld_tk}), 72'(exp_ld));
      if (exp_ld[2]) chk(ld_hi_v == dat_w[7:0], "R3 upper seconds value", 72'(ld_hi_v), 72'(dat_w[7:0]));
      if (exp_ld[1]) chk(ld_lo_v == dat_w, "R3 lower seconds value", 72'(ld_lo_v), 72'(dat_w));
      if (exp_ld[0]) chk(ld_tk_v == dat_w[27:0], "R3 tick value", 72'(ld_tk_v), 72'(dat_w[27:0]));
      if (req && !we) begin
        automatic logic [31:0] e = ref_read(w);
        automatic string tag = (w < 3) ? "R2 running time read" :
                               (w < 6) ? "R4 trigger time read" :
                               (w < 18) ? "R5 event read" : "R6 unmapped read";
        chk(dat_r == e, tag, 72'(dat_r), 72'(e));
      end
      if (req && we) begin
        if (w == 3) m_trg_sec[39:32] = dat_w[7:0];
        if (w == 4) m_trg_sec[31:0]  = dat_w;
        if (w == 5) m_trg_tick       = dat_w[27:0];
      end
      chk({trg_sec, trg_tick} == {m_trg_sec, m_trg_tick}, "R4 trigger time outputs",
          72'({trg_sec, trg_tick}), 72'({m_trg_sec, m_trg_tick}));
    end
  end

  task automatic drive(bit w_en, int word, logic [31:0] d, logic [1:0] lsb = 2'b00);
    cyc = 1'b1; stb = 1'b1; we = w_en;
    adr = {5'(word), lsb};
    dat_w = d;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    idle(2);
    // R2 R4 R5 R6: read the whole window as one burst
    for (int i = 0; i < 32; i++) drive(0, i, 32'h0);
    idle(1);
    // R3: load the running time near a tick rollover
    drive(1, 0, 32'hFFFF_FFA5);
    drive(1, 1, 32'h1234_5678);
    drive(1, 2, 32'hF773_5937);
    idle(1);
    for (int r = 0; r < 6; r++) drive(0, r % 3, 32'h0, 2'(r));
    idle(2);
    // R4: trigger time storage with oversize data
    drive(1, 3, 32'hDEAD_BEEF);
    idle(1);
    drive(1, 4, 32'hCAFE_F00D);
    drive(1, 5, 32'hFFFF_FFFF);
    for (int i = 3; i < 6; i++) drive(0, i, 32'h0);
    idle(1);
    // R5: event inputs; writes to them are ignored
    for (int k = 0; k < N_EVT; k++) begin
      evt_sec[k]  = {8'(8'hA0 + k), 32'(32'h1000_0000 * k + 32'h0123_4567)};
      evt_tick[k] = 28'(28'h0ABC_DE0 + k);
    end
    for (int i = 6; i < 18; i++) drive(1, i, 32'hFFFF_FFFF);
    for (int i = 6; i < 18; i++) drive(0, i, 32'h0);
    idle(1);
    // R6: unmapped writes leave everything unchanged
    for (int i = 18; i < 32; i++) drive(1, i, 32'h5A5A_5A5A);
    for (int i = 0; i < 32; i++) drive(0, i, 32'h0);
    idle(2);
    // R3: back-to-back loads
    drive(1, 2, 32'h0000_0010);
    drive(1, 1, 32'h0000_0001);
    drive(1, 0, 32'h0000_0002);
    drive(0, 2, 32'h0);
    drive(0, 1, 32'h0);
    idle(3);
    // R7: reset during operation
    rst_ni = 1'b0;
    idle(2);
    rst_ni = 1'b1;
    idle(1);
    for (int i = 0; i < 6; i++) drive(0, i, 32'h0);
    idle(3);
    finish_run();
  end
endmodule